// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four active-low PCI interrupt lines onto a 16-entry vector of interrupt-controller inputs. Each line has its own 8-bit route-control register. Software reaches these registers through a simple configuration port at four consecutive offsets. Each register holds two fields:

- a disconnect bit;
- a 4-bit target code. Only eleven values of this code name a real IRQ.

Each output IRQ that has at least one line routed onto it is driven from those lines, and the legacy source pin for that IRQ is masked. An output IRQ that no line is routed onto carries its legacy source pin unchanged.

The block also raises a flag for a routing mistake: a line routed to an IRQ that the interrupt controller has not set to level-sensitive mode. The controller supplies its per-IRQ level-mode bits for this check. The vector of IRQ outputs and the flag are registered. Both follow the inputs and the register contents with one cycle of latency.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is held, and after it, every route register reads 80h: the line is disconnected and the code is 0.
- R2: Register bit 7 is the disconnect bit, and bits 3:0 are the target code. Bits 6:4 always read as 0, and writes to them are ignored.
- R3: Offsets 60h, 61h, 62h and 63h select the registers of lines 0, 1, 2 and 3. A write to any other offset changes no register, and a read from any other offset returns 0.
- R4: For an enabled line with a legal code, output IRQ n is high one cycle after the line goes low, where n is the code value. The legal codes are 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15.
- R5: A line whose code is 0, 1, 2, 8 or 13 drives no output and masks no legacy pin.
- R6: A line whose bit 7 is 1 drives no output and masks no legacy pin, whatever its code.
- R7: Any number of lines may share one IRQ. That IRQ is high when at least one of the lines routed to it is low.
- R8: An IRQ with at least one line routed to it ignores its legacy source pin.
- R9: An IRQ with no line routed to it outputs its legacy source pin, delayed by one cycle.
- R10: One cycle after its inputs, level_err is high exactly when some IRQ with at least one routed line has its level_mode bit at 0.
- R11: A register write is visible on cfg_rdata in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data of the addressed register (combinational) |
| pci_int_n | input | 4 | PCI interrupt lines, active low |
| legacy_irq | input | 16 | Legacy IRQ source pins, active high |
| level_mode | input | 16 | Per-IRQ level-sensitive setting from the interrupt controller |
| irq_out | output | 16 | Routed interrupt-controller inputs |
| level_err | output | 1 | A routed IRQ is not in level mode |

## Verification
A wrong disconnect bit or target code shows up in the cycle after the write, as a wrong cfg_rdata byte. From the next clock edge onward, the same fault appears as one of two output errors:
- an IRQ that follows the legacy pin when it should follow a PCI line;
- an IRQ that follows a PCI line when it should follow the legacy pin.

The bench covers every line with every code in both the enabled and the disconnected state, and drives each case with both the PCI line and the legacy pins as the active source. Every routing fault therefore shows on irq_out, or on level_err, one cycle after the stimulus.

// File: rtl/pir_pkg.sv
package pir_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned DIS_BIT  = 7;
    localparam int unsigned FIELD_W  = 4;
    localparam logic [REG_W-1:0] RW_MASK   = 8'h8F;
    localparam logic [REG_W-1:0] RST_VALUE = 8'h80;

    // Keeps only the writable fields of a route byte.
    function automatic logic [REG_W-1:0] clean_route(input logic [REG_W-1:0] w);
        return w & RW_MASK;
    endfunction
endpackage

// File: rtl/pir_line_decode.sv
module pir_line_decode #(
    parameter int unsigned NUM_IRQ    = 16,
    parameter int unsigned CODE_W     = 4,
    parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8
) (
    input  logic              dis,
    input  logic [CODE_W-1:0] code,
    output logic [NUM_IRQ-1:0] target
);
    always_comb begin
        target = '0;
        if (!dis && (int'(code) < NUM_IRQ)) begin
            if (LEGAL_MASK[code]) begin
                target[code] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pir_irq_merge.sv
module pir_irq_merge #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned NUM_IRQ   = 16
) (
    input  logic [NUM_LINES-1:0][NUM_IRQ-1:0] target,
    input  logic [NUM_LINES-1:0] line_n,
    input  logic [NUM_IRQ-1:0]   legacy,
    input  logic [NUM_IRQ-1:0]   level_mode,
    output logic [NUM_IRQ-1:0]   irq_next,
    output logic                 lvl_err_next
);
    logic [NUM_IRQ-1:0] routed;
    logic [NUM_IRQ-1:0] active;

    always_comb begin
        routed = '0;
        active = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            routed = routed | target[l];
            if (!line_n[l]) begin
                active = active | target[l];
            end
        end
        irq_next     = (routed & active) | (~routed & legacy);
        lvl_err_next = |(routed & ~level_mode);
    end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
    parameter int unsigned NUM_LINES   = 4,
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  BASE_OFFSET = 8'h60,
    parameter logic [15:0] LEGAL_MASK  = 16'hDEF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic [NUM_LINES-1:0] pci_int_n,
    input  logic [NUM_IRQ-1:0]   legacy_irq,
    input  logic [NUM_IRQ-1:0]   level_mode,
    output logic [NUM_IRQ-1:0]   irq_out,
    output logic                 level_err
);
    import pir_pkg::*;

    localparam int unsigned CODE_W = $clog2(NUM_IRQ);
    localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    typedef struct packed {
        logic [NUM_LINES-1:0]             dis;
        logic [NUM_LINES-1:0][CODE_W-1:0] code;
        logic [NUM_IRQ-1:0]               irq;
        logic                             lvl_err;
    } state_t;

    localparam state_t RST_ST = '{dis: '1, code: '0, irq: '0, lvl_err: 1'b0};

    state_t st_d, st_q;

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [LINE_W-1:0] idx;
    logic [REG_W-1:0]  wclean;

    logic [NUM_LINES-1:0][NUM_IRQ-1:0] target;
    logic [NUM_IRQ-1:0] irq_next;
    logic               lvl_err_next;

    assign off    = cfg_addr - ADDR_W'(BASE_OFFSET);
    assign hit    = off < ADDR_W'(NUM_LINES);
    assign idx    = off[LINE_W-1:0];
    assign wclean = clean_route(cfg_wdata);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        pir_line_decode #(
            .NUM_IRQ    (NUM_IRQ),
            .CODE_W     (CODE_W),
            .LEGAL_MASK (LEGAL_MASK[NUM_IRQ-1:0])
        ) dec_i (
            .dis    (st_q.dis[g]),
            .code   (st_q.code[g]),
            .target (target[g])
        );
    end

    pir_irq_merge #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQ   (NUM_IRQ)
    ) merge_i (
        .target       (target),
        .line_n       (pci_int_n),
        .legacy       (legacy_irq),
        .level_mode   (level_mode),
        .irq_next     (irq_next),
        .lvl_err_next (lvl_err_next)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we && hit) begin
            st_d.dis[idx]  = wclean[DIS_BIT];
            st_d.code[idx] = wclean[CODE_W-1:0];
        end
        st_d.irq     = irq_next;
        st_d.lvl_err = lvl_err_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[DIS_BIT]    = st_q.dis[idx];
            cfg_rdata[CODE_W-1:0] = st_q.code[idx];
        end
    end

    assign irq_out   = st_q.irq;
    assign level_err = st_q.lvl_err;
endmodule

// File: rtl/pci_irq_router_sva.sv
module pci_irq_router_sva #(
    parameter int unsigned NUM_LINES   = 4,
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  BASE_OFFSET = 8'h60
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic [7:0]           cfg_wdata,
    input logic [7:0]           cfg_rdata,
    input logic [NUM_LINES-1:0] pci_int_n,
    input logic [NUM_IRQ-1:0]   legacy_irq,
    input logic [NUM_IRQ-1:0]   level_mode,
    input logic [NUM_IRQ-1:0]   irq_out,
    input logic                 level_err
);
    logic in_range;
    assign in_range = (cfg_addr >= ADDR_W'(BASE_OFFSET)) &&
                      (cfg_addr <  ADDR_W'(BASE_OFFSET) + ADDR_W'(NUM_LINES));

    // R1: registers read 80h while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_value: assert (cfg_rdata == (in_range ? 8'h80 : 8'h00));
        end
    end

    // R2: reserved bits never read as set
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:4] == 3'b000);

    // R3: offsets outside the window read zero
    a_r3_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> cfg_rdata == 8'h00);

    // R11: a write is visible on the next cycle when the same offset is read
    a_r11_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && in_range) |=> (cfg_addr != $past(cfg_addr)) ||
            (cfg_rdata == {$past(cfg_wdata[7]), 3'b000, $past(cfg_wdata[3:0])}));

    // R8: with no PCI line asserted, no output can be high without its legacy pin
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (&pci_int_n) |=> ((irq_out & ~$past(legacy_irq)) == '0));

    // R4: all sources idle gives an idle output vector
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pci_int_n) && (legacy_irq == '0)) |=> irq_out == '0);

    // R10: every IRQ in level mode leaves no error
    a_r10_all_level_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (&level_mode) |=> !level_err);
endmodule

bind pci_irq_router pci_irq_router_sva #(
    .NUM_LINES   (NUM_LINES),
    .NUM_IRQ     (NUM_IRQ),
    .ADDR_W      (ADDR_W),
    .BASE_OFFSET (BASE_OFFSET)
) sva_i (.*);

// File: tb/pci_irq_router_tb_top.sv
`timescale 1ns/1ps
module pci_irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_int_n = 4'hF;
    logic [15:0] legacy_irq = '0;
    logic [15:0] level_mode = '1;
    logic [15:0] irq_out;
    logic        level_err;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [7:0] mreg [4];

    always #5 clk = ~clk;

    pci_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int_n(pci_int_n),
        .legacy_irq(legacy_irq), .level_mode(level_mode), .irq_out(irq_out),
        .level_err(level_err)
    );

    function automatic logic legal(input logic [3:0] c);
        return !(c inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd13});
    endfunction

    function automatic logic [15:0] routed_map();
        logic [15:0] r = '0;
        for (int l = 0; l < 4; l++)
            if (!mreg[l][7] && legal(mreg[l][3:0])) r[mreg[l][3:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] r = routed_map();
        logic [15:0] a = '0;
        for (int l = 0; l < 4; l++)
            if (!mreg[l][7] && legal(mreg[l][3:0]) && !pci_int_n[l]) a[mreg[l][3:0]] = 1'b1;
        return (r & a) | (~r & legacy_irq);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h60 && a <= 8'h63) mreg[a - 8'h60] = d & 8'h8F;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a; #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic drive_chk(input logic [3:0] p, input logic [15:0] lg, input string tag);
        pci_int_n = p; legacy_irq = lg;
        @(posedge clk); @(negedge clk);
        chk(irq_out == exp_irq(), tag, irq_out, exp_irq());
    endtask

    task automatic lvl_chk(input logic [15:0] lm, input string tag);
        logic e;
        level_mode = lm;
        @(posedge clk); @(negedge clk);
        e = |(routed_map() & ~lm);
        chk(level_err == e, tag, level_err, e);
    endtask

    initial begin
        for (int l = 0; l < 4; l++) mreg[l] = 8'h80;
        @(negedge clk); @(negedge clk);
        // R1: values during reset
        rd_chk(8'h60, 8'h80, "R1 reset in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < 4; l++) rd_chk(8'h60 + 8'(l), 8'h80, "R1 reset value");
        // R9: nothing routed, legacy passes through
        drive_chk(4'h0, 16'hA5C3, "R9 legacy passthrough");
        drive_chk(4'h0, 16'h5A3C, "R9 legacy passthrough");

        // R2 / R11: reserved bits dropped, readback next cycle
        wr(8'h61, 8'hF5);
        rd_chk(8'h61, 8'h85, "R2 R11 reserved bits ignored");
        wr(8'h61, 8'h7A);
        rd_chk(8'h61, 8'h0A, "R2 R11 readback");
        wr(8'h61, 8'h80);
        // R3: outside window
        wr(8'h64, 8'h05); wr(8'h5F, 8'h05); wr(8'hE0, 8'h05);
        rd_chk(8'h64, 8'h00, "R3 outside reads zero");
        rd_chk(8'h5F, 8'h00, "R3 outside reads zero");
        for (int l = 0; l < 4; l++) rd_chk(8'h60 + 8'(l), 8'h80, "R3 outside write ignored");
        drive_chk(4'h0, 16'h0000, "R3 no route after outside write");

        // R4 R5 R6 R8 R9: sweep line, code, enable
        for (int l = 0; l < 4; l++) begin
            for (int c = 0; c < 16; c++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [7:0] v = {en == 0, 3'b000, 4'(c)};
                    wr(8'h60 + 8'(l), v);
                    rd_chk(8'h60 + 8'(l), v, "R11 sweep readback");
                    drive_chk(~(4'b1 << l), 16'h0000,
                              (en == 1 && legal(4'(c))) ? "R4 routed drive" :
                              (en == 1) ? "R5 reserved code" : "R6 disconnected");
                    drive_chk(4'hF, 16'hFFFF, "R8 R9 legacy masking");
                    drive_chk(~(4'b1 << l), 16'hFFFF, "R8 R9 mixed sources");
                end
            end
            wr(8'h60 + 8'(l), 8'h80);
        end

        // R7: all lines share IRQ10
        for (int l = 0; l < 4; l++) wr(8'h60 + 8'(l), 8'h0A);
        for (int p = 0; p < 16; p++) drive_chk(4'(p), 16'h0000, "R7 shared irq");

        // R7 R8 R9: mixed routing 3, 9, 9, 15
        wr(8'h60, 8'h03); wr(8'h61, 8'h09); wr(8'h62, 8'h09); wr(8'h63, 8'h0F);
        for (int p = 0; p < 16; p++) begin
            drive_chk(4'(p), 16'h8208, "R8 mixed routing");
            drive_chk(4'(p), 16'h7DF7, "R9 mixed routing");
        end

        // R10: level mode flag
        pci_int_n = 4'hF; legacy_irq = '0;
        wr(8'h61, 8'h80); wr(8'h62, 8'h80); wr(8'h63, 8'h80);
        wr(8'h60, 8'h05);
        lvl_chk(16'hFFFF, "R10 all level");
        lvl_chk(~16'h0020, "R10 routed irq edge mode");
        lvl_chk(~16'h0040, "R10 unrouted irq edge mode");
        wr(8'h60, 8'h08);
        lvl_chk(~16'h0100, "R10 reserved code not routed");
        wr(8'h60, 8'h85);
        lvl_chk(~16'h0020, "R10 disconnected line");
        wr(8'h60, 8'h0E);
        lvl_chk(~16'h4000, "R10 routed irq14 edge mode");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule